// File: doc/BRIEF.md
# Single-Channel Register-Programmed DMA Engine

This block is one channel of a DMA controller. Software programs it through a small 32-bit register window: a source address, a destination address, a count of transfer units, a request mode, a status/control word, a command word, a global control word and a read-only interrupt-pending word. Once enabled, the engine copies data one unit at a time over a single-beat memory port. Each unit is a read followed by a write. Units larger than a word are split into a burst of word beats.

The count is kept in transfer units, not bytes, and counts down as units finish. Both address registers read back their current, advanced values. Each address can step or stay fixed, chosen independently. When the count runs out, the channel sets sticky done and count-terminated flags and may raise its interrupt. Software clears these flags by rewriting the status word. Movement is gated by four bits: the channel enable and halt bits, and the global enable and halt bits. A misaligned start raises an address error instead of moving any data.

Top module: `dma_chan_top`

## Requirements
- R1: After reset every register in the window reads zero, `irq_o` is low and no memory request is made. Register offsets are: 0x00 source, 0x04 destination, 0x08 count, 0x0C request mode, 0x10 status/control, 0x14 command, 0x18 global control, 0x1C interrupt pending.
- R2: When the last unit's write completes, status bit 3 (done) and bit 1 (count terminated) become set. Enable (bit 0) stays as written. No further memory access is made until software clears done, and the destination holds the copied bytes.
- R3: With command bit 23 set, the source address advances by the unit's byte step after each write beat; command bit 22 does the same for the destination. With the bit clear, the address holds. Both address registers read back their current values.
- R4: Command bits 10:8 select the unit: code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes, 4 = 32 bytes. Units of 16 and 32 bytes run as bursts of 4 and 8 word beats. Sub-word units take bytes from the source's byte lane and write them to the destination's byte lane under a matching byte enable.
- R5: The count register holds remaining units and drops by exactly one per completed unit. It is readable while a transfer is under way.
- R6: `irq_o` and bit 0 of the pending word equal done AND command bit 1. Writing the status word with done cleared removes the request.
- R7: At the start of a unit, if either address is not a multiple of the unit size, the engine sets status bit 4 (address error) and clears enable. It does not set done and makes no memory access.
- R8: Enabling with a count of zero sets done and count-terminated on the next clock edge without any memory access.
- R9: Data moves only while status bit 0 is set, status bit 2 (halt) is clear, global-control bit 0 (enable) is set and global-control bit 3 (halt) is clear. Otherwise the count and addresses stay still.
- R10: With request-mode bit 0 set, each unit starts only in a cycle where `dreq_i` is high. With the bit clear, units run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_sel_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when high, read when low |
| reg_addr_i | input | 5 | Byte offset in the window |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| dreq_i | input | 1 | Peripheral request for request mode |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Word-aligned beat address |
| mem_be_o | output | 4 | Byte enables of a write beat |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with `mem_ready_i` |
| mem_ready_i | input | 1 | Beat accepted this cycle |
| irq_o | output | 1 | Channel interrupt request |

## Verification
The hardest state to reach from the ports is a transfer frozen part way, where the remaining count and the advanced addresses must be visible and stable. The bench gets there in two ways. It uses request mode and pulses `dreq_i` for a single cycle, so exactly one unit runs and the engine then parks in idle. It also sets the global or channel halt bit before enabling, so the count can be sampled while nothing moves. Burst units are additionally run against a memory that accepts beats only every other cycle, so the beat sequencing is exercised with stalls.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int REG_AW = 5;

    // Register offsets inside the channel window
    localparam logic [REG_AW-1:0] OFS_SRC  = 5'h00;
    localparam logic [REG_AW-1:0] OFS_DST  = 5'h04;
    localparam logic [REG_AW-1:0] OFS_CNT  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_RQT  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_STS  = 5'h10;
    localparam logic [REG_AW-1:0] OFS_CMD  = 5'h14;
    localparam logic [REG_AW-1:0] OFS_GCTL = 5'h18;
    localparam logic [REG_AW-1:0] OFS_PEND = 5'h1C;

    // Status/control bits
    localparam int STS_EN   = 0;
    localparam int STS_CT   = 1;
    localparam int STS_HALT = 2;
    localparam int STS_DONE = 3;
    localparam int STS_AERR = 4;

    // Command bits
    localparam int CMD_SINC  = 23;
    localparam int CMD_DINC  = 22;
    localparam int CMD_USZ   = 8;
    localparam int CMD_IRQEN = 1;

    // Global control bits
    localparam int GCTL_EN   = 0;
    localparam int GCTL_HALT = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } chan_state_e;

endpackage

// File: rtl/dma_chan_unit.sv
// Decodes the unit-size code into beat step, beat count and alignment mask.
module dma_chan_unit #(
    parameter int BEAT_W = 3
) (
    input  logic [2:0]        code_i,
    output logic [2:0]        step_o,
    output logic [BEAT_W-1:0] beats_m1_o,
    output logic [4:0]        align_mask_o
);
    always_comb begin
        step_o       = 3'd1;
        beats_m1_o   = '0;
        align_mask_o = 5'd0;
        unique case (code_i)
            3'd1: begin step_o = 3'd2; align_mask_o = 5'd1; end
            3'd2: begin step_o = 3'd4; align_mask_o = 5'd3; end
            3'd3: begin step_o = 3'd4; beats_m1_o = BEAT_W'(3); align_mask_o = 5'd15; end
            3'd4: begin step_o = 3'd4; beats_m1_o = BEAT_W'(7); align_mask_o = 5'd31; end
            default: ;
        endcase
    end
endmodule

// File: rtl/dma_chan_lane.sv
// Moves sub-word units from the source byte lane to the destination byte lane.
module dma_chan_lane #(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8,
    localparam int LO_W  = $clog2(BE_W)
) (
    input  logic [LO_W-1:0]   src_lo_i,
    input  logic [LO_W-1:0]   dst_lo_i,
    input  logic [2:0]        step_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic [BE_W-1:0]   be_o
);
    logic [DATA_W-1:0] aligned;
    logic [BE_W-1:0]   base_mask;

    // One enable bit per byte of the unit
    for (genvar g = 0; g < BE_W; g++) begin : g_mask
        assign base_mask[g] = (g < int'(step_i));
    end

    assign aligned = rdata_i >> {src_lo_i, 3'b000};
    assign wdata_o = aligned << {dst_lo_i, 3'b000};
    assign be_o    = base_mask << dst_lo_i;
endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
    import dma_chan_pkg::*;
#(
    parameter int COUNT_W = 24,
    parameter int DATA_W  = 32,
    parameter int BEAT_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_sel_i,
    input  logic              reg_we_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              dreq_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [DATA_W/8-1:0] mem_be_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              irq_o
);
    localparam int BE_W = DATA_W / 8;
    localparam int LO_W = $clog2(BE_W);

    typedef struct packed {
        chan_state_e        st;
        logic [31:0]        src;
        logic [31:0]        dst;
        logic [COUNT_W-1:0] cnt;
        logic               rqt;
        logic               en;
        logic               ct;
        logic               halt;
        logic               done;
        logic               aerr;
        logic               sinc;
        logic               dinc;
        logic [2:0]         usz;
        logic               irqen;
        logic               gen;
        logic               ghalt;
        logic [BEAT_W-1:0]  beat;
        logic [DATA_W-1:0]  data;
    } chan_regs_t;

    chan_regs_t r_d, r_q;

    logic [2:0]        step;
    logic [BEAT_W-1:0] beats_m1;
    logic [4:0]        align_mask;
    logic [DATA_W-1:0] lane_wdata;
    logic [BE_W-1:0]   lane_be;
    logic              run;
    logic              misalign;
    logic              reg_wr;
    logic              unused_wdata;

    dma_chan_unit #(.BEAT_W(BEAT_W)) unit_i (
        .code_i      (r_q.usz),
        .step_o      (step),
        .beats_m1_o  (beats_m1),
        .align_mask_o(align_mask)
    );

    dma_chan_lane #(.DATA_W(DATA_W)) lane_i (
        .src_lo_i(r_q.src[LO_W-1:0]),
        .dst_lo_i(r_q.dst[LO_W-1:0]),
        .step_i  (step),
        .rdata_i (r_q.data),
        .wdata_o (lane_wdata),
        .be_o    (lane_be)
    );

    assign run          = r_q.en && !r_q.halt && r_q.gen && !r_q.ghalt;
    assign misalign     = |((r_q.src[4:0] | r_q.dst[4:0]) & align_mask);
    assign reg_wr       = reg_sel_i && reg_we_i;
    assign irq_o        = r_q.done && r_q.irqen;
    assign unused_wdata = ^reg_wdata_i;

    always_comb begin
        r_d         = r_q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = {r_q.src[31:LO_W], {LO_W{1'b0}}};
        mem_be_o    = '0;
        mem_wdata_o = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (run && !r_q.done && !r_q.aerr) begin
                    if (misalign) begin
                        r_d.aerr = 1'b1;
                        r_d.en   = 1'b0;
                    end else if (r_q.cnt == '0) begin
                        r_d.done = 1'b1;
                        r_d.ct   = 1'b1;
                    end else if (!r_q.rqt || dreq_i) begin
                        r_d.st   = ST_READ;
                        r_d.beat = '0;
                    end
                end
            end
            ST_READ: begin
                if (run) begin
                    mem_req_o = 1'b1;
                    if (mem_ready_i) begin
                        r_d.data = mem_rdata_i;
                        r_d.st   = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = {r_q.dst[31:LO_W], {LO_W{1'b0}}};
                mem_be_o    = lane_be;
                mem_wdata_o = lane_wdata;
                if (mem_ready_i) begin
                    if (r_q.sinc) r_d.src = r_q.src + {29'd0, step};
                    if (r_q.dinc) r_d.dst = r_q.dst + {29'd0, step};
                    if (r_q.beat == beats_m1) begin
                        r_d.cnt = r_q.cnt - {{(COUNT_W-1){1'b0}}, 1'b1};
                        r_d.st  = ST_IDLE;
                        if (r_q.cnt == {{(COUNT_W-1){1'b0}}, 1'b1}) begin
                            r_d.done = 1'b1;
                            r_d.ct   = 1'b1;
                        end
                    end else begin
                        r_d.beat = r_q.beat + {{(BEAT_W-1){1'b0}}, 1'b1};
                        r_d.st   = ST_READ;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // Software writes take precedence over engine updates
        if (reg_wr) begin
            unique case (reg_addr_i)
                OFS_SRC: r_d.src = reg_wdata_i;
                OFS_DST: r_d.dst = reg_wdata_i;
                OFS_CNT: r_d.cnt = reg_wdata_i[COUNT_W-1:0];
                OFS_RQT: r_d.rqt = reg_wdata_i[0];
                OFS_STS: begin
                    r_d.en   = reg_wdata_i[STS_EN];
                    r_d.ct   = reg_wdata_i[STS_CT];
                    r_d.halt = reg_wdata_i[STS_HALT];
                    r_d.done = reg_wdata_i[STS_DONE];
                    r_d.aerr = reg_wdata_i[STS_AERR];
                end
                OFS_CMD: begin
                    r_d.sinc  = reg_wdata_i[CMD_SINC];
                    r_d.dinc  = reg_wdata_i[CMD_DINC];
                    r_d.usz   = reg_wdata_i[CMD_USZ+:3];
                    r_d.irqen = reg_wdata_i[CMD_IRQEN];
                end
                OFS_GCTL: begin
                    r_d.gen   = reg_wdata_i[GCTL_EN];
                    r_d.ghalt = reg_wdata_i[GCTL_HALT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            OFS_SRC: reg_rdata_o = r_q.src;
            OFS_DST: reg_rdata_o = r_q.dst;
            OFS_CNT: reg_rdata_o = 32'(r_q.cnt);
            OFS_RQT: reg_rdata_o = {31'd0, r_q.rqt};
            OFS_STS: begin
                reg_rdata_o[STS_EN]   = r_q.en;
                reg_rdata_o[STS_CT]   = r_q.ct;
                reg_rdata_o[STS_HALT] = r_q.halt;
                reg_rdata_o[STS_DONE] = r_q.done;
                reg_rdata_o[STS_AERR] = r_q.aerr;
            end
            OFS_CMD: begin
                reg_rdata_o[CMD_SINC]     = r_q.sinc;
                reg_rdata_o[CMD_DINC]     = r_q.dinc;
                reg_rdata_o[CMD_USZ+:3]   = r_q.usz;
                reg_rdata_o[CMD_IRQEN]    = r_q.irqen;
            end
            OFS_GCTL: begin
                reg_rdata_o[GCTL_EN]   = r_q.gen;
                reg_rdata_o[GCTL_HALT] = r_q.ghalt;
            end
            OFS_PEND: reg_rdata_o = {31'd0, irq_o};
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk
    import dma_chan_pkg::*;
#(
    parameter int COUNT_W = 24,
    parameter int BE_W    = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               reg_sel_i,
    input logic               reg_we_i,
    input logic [REG_AW-1:0]  reg_addr_i,
    input logic               mem_req_i,
    input logic               mem_we_i,
    input logic [BE_W-1:0]    mem_be_i,
    input logic               irq_i,
    input logic               run_i,
    input logic               done_i,
    input logic               aerr_i,
    input logic [COUNT_W-1:0] cnt_i
);
    logic cnt_wr;
    assign cnt_wr = reg_sel_i && reg_we_i && (reg_addr_i == OFS_CNT);

    assert_done_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> !mem_req_i);

    assert_be_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_i && mem_we_i) |-> (mem_be_i != '0));

    assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(cnt_wr) && (cnt_i != $past(cnt_i)))
            |-> (cnt_i == ($past(cnt_i) - {{(COUNT_W-1){1'b0}}, 1'b1})));

    assert_irq_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> done_i);

    assert_err_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        aerr_i |-> !mem_req_i);

    assert_read_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_i && !mem_we_i) |-> run_i);

endmodule

bind dma_chan_top dma_chan_chk #(.COUNT_W(COUNT_W), .BE_W(DATA_W/8)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reg_sel_i (reg_sel_i),
    .reg_we_i  (reg_we_i),
    .reg_addr_i(reg_addr_i),
    .mem_req_i (mem_req_o),
    .mem_we_i  (mem_we_o),
    .mem_be_i  (mem_be_o),
    .irq_i     (irq_o),
    .run_i     (run),
    .done_i    (r_q.done),
    .aerr_i    (r_q.aerr),
    .cnt_i     (r_q.cnt)
);

// File: tb/dma_chan_top_tb.sv
module dma_chan_top_tb_top;

    localparam logic [4:0] A_SRC = 5'h00, A_DST = 5'h04, A_CNT = 5'h08, A_RQT = 5'h0C,
                           A_STS = 5'h10, A_CMD = 5'h14, A_GCTL = 5'h18, A_PEND = 5'h1C;
    localparam logic [31:0] C_SINC = 32'h0080_0000, C_DINC = 32'h0040_0000, C_IRQ = 32'h2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        dreq = 1'b0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        irq;

    logic [7:0]  mem_b [256];
    logic [7:0]  gold  [256];
    int          accesses = 0;
    int          n_checks = 0, n_fail = 0;
    logic        stall_mode = 1'b0;
    logic        phase = 1'b0;

    always #5 clk = ~clk;

    dma_chan_top dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_sel_i(reg_sel), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dreq_i(dreq),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .mem_ready_i(mem_ready), .irq_o(irq)
    );

    assign mem_ready = stall_mode ? phase : 1'b1;
    assign mem_rdata = {mem_b[{mem_addr[7:2], 2'd3}], mem_b[{mem_addr[7:2], 2'd2}],
                        mem_b[{mem_addr[7:2], 2'd1}], mem_b[{mem_addr[7:2], 2'd0}]};

    always @(posedge clk) begin
        phase <= ~phase;
        if (mem_req && mem_ready) begin
            accesses <= accesses + 1;
            if (mem_we)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem_b[{mem_addr[7:2], 2'(b)}] <= mem_wdata[8*b +: 8];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic init_mem();
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            mem_b[i] = 8'((i * 7 + 3) ^ 8'h5A);
            gold[i]  = mem_b[i];
        end
        accesses = 0;
    endtask

    task automatic wait_done(input int limit);
        logic [31:0] s;
        for (int i = 0; i < limit; i++) begin
            rd(A_STS, s);
            if (s[3]) break;
            @(posedge clk);
        end
    endtask

    task automatic clear_status();
        wr(A_STS, 32'h0);
    endtask

    // Count byte mismatches between destination region and expected source bytes
    function automatic int mism(input int dst, input int src, input int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (mem_b[dst + i] !== gold[src + i]) m++;
        return m;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v);
            chk("R1", v, 32'h0, $sformatf("reg %0h after reset", a * 4));
        end
        chk("R1", {31'd0, irq}, 32'h0, "irq after reset");
        chk("R1", {31'd0, mem_req}, 32'h0, "mem_req after reset");
    endtask

    task automatic t_word_copy();
        logic [31:0] v;
        init_mem();
        wr(A_GCTL, 32'h1);
        wr(A_SRC, 32'h00); wr(A_DST, 32'h80); wr(A_CNT, 32'd4);
        wr(A_CMD, C_SINC | C_DINC | (32'd2 << 8) | C_IRQ);
        wr(A_STS, 32'h1);
        wait_done(200);
        repeat (4) @(posedge clk);
        chk("R2", 32'(mism(8'h80, 0, 16)), 32'h0, "word copy data");
        chk("R2", 32'(accesses), 32'd8, "word copy access count");
        rd(A_STS, v); chk("R2", v, 32'hB, "status after completion");
        rd(A_CNT, v); chk("R5", v, 32'h0, "count after completion");
        rd(A_SRC, v); chk("R3", v, 32'h10, "source advanced");
        rd(A_DST, v); chk("R3", v, 32'h90, "destination advanced");
        chk("R6", {31'd0, irq}, 32'h1, "irq on completion");
        rd(A_PEND, v); chk("R6", v, 32'h1, "pending bit");
        clear_status();
        chk("R6", {31'd0, irq}, 32'h0, "irq after acknowledge");
    endtask

    task automatic t_byte_lanes();
        init_mem();
        wr(A_SRC, 32'h41); wr(A_DST, 32'h82); wr(A_CNT, 32'd3);
        wr(A_CMD, C_SINC | C_DINC);
        wr(A_STS, 32'h1);
        wait_done(200);
        chk("R4", 32'(mism(8'h82, 8'h41, 3)), 32'h0, "byte unit lane move");
        chk("R4", {24'd0, mem_b[8'h81]}, {24'd0, gold[8'h81]}, "byte below untouched");
        chk("R4", {24'd0, mem_b[8'h85]}, {24'd0, gold[8'h85]}, "byte above untouched");
        clear_status();
        init_mem();
        wr(A_SRC, 32'h42); wr(A_DST, 32'hA0); wr(A_CNT, 32'd2);
        wr(A_CMD, C_SINC | C_DINC | (32'd1 << 8));
        wr(A_STS, 32'h1);
        wait_done(200);
        chk("R4", 32'(mism(8'hA0, 8'h42, 4)), 32'h0, "half-word unit move");
        clear_status();
    endtask

    task automatic t_burst();
        logic [31:0] v;
        init_mem();
        stall_mode = 1'b1;
        wr(A_SRC, 32'h20); wr(A_DST, 32'hC0); wr(A_CNT, 32'd1);
        wr(A_CMD, C_SINC | C_DINC | (32'd4 << 8));
        wr(A_STS, 32'h1);
        wait_done(400);
        repeat (2) @(posedge clk);
        chk("R4", 32'(mism(8'hC0, 8'h20, 32)), 32'h0, "32-byte burst data");
        chk("R4", 32'(accesses), 32'd16, "32-byte burst beats");
        clear_status();
        init_mem();
        wr(A_SRC, 32'h10); wr(A_DST, 32'hA0); wr(A_CNT, 32'd2);
        wr(A_CMD, C_SINC | C_DINC | (32'd3 << 8));
        wr(A_STS, 32'h1);
        wait_done(400);
        repeat (2) @(posedge clk);
        stall_mode = 1'b0;
        chk("R4", 32'(mism(8'hA0, 8'h10, 32)), 32'h0, "16-byte units data");
        chk("R4", 32'(accesses), 32'd16, "16-byte units beats");
        rd(A_DST, v); chk("R3", v, 32'hC0, "destination after bursts");
        clear_status();
    endtask

    task automatic t_fixed_dst();
        logic [31:0] v;
        init_mem();
        wr(A_SRC, 32'h20); wr(A_DST, 32'hC0); wr(A_CNT, 32'd3);
        wr(A_CMD, C_SINC | (32'd2 << 8));
        wr(A_STS, 32'h1);
        wait_done(200);
        chk("R3", 32'(mism(8'hC0, 8'h28, 4)), 32'h0, "held destination keeps last word");
        chk("R3", 32'(mism(8'hC4, 8'hC4, 4)), 32'h0, "next word untouched");
        rd(A_DST, v); chk("R3", v, 32'hC0, "destination held");
        rd(A_SRC, v); chk("R3", v, 32'h2C, "source advanced");
        clear_status();
    endtask

    task automatic t_misalign();
        logic [31:0] v;
        init_mem();
        wr(A_SRC, 32'h02); wr(A_DST, 32'h80); wr(A_CNT, 32'd2);
        wr(A_CMD, C_SINC | C_DINC | (32'd2 << 8) | C_IRQ);
        wr(A_STS, 32'h1);
        repeat (5) @(posedge clk);
        rd(A_STS, v); chk("R7", v, 32'h10, "address error, enable cleared, no done");
        chk("R7", 32'(accesses), 32'd0, "no access on misalign");
        chk("R7", {31'd0, irq}, 32'h0, "no irq on misalign");
        rd(A_CNT, v); chk("R7", v, 32'd2, "count untouched on misalign");
        clear_status();
    endtask

    task automatic t_zero_count();
        logic [31:0] v;
        init_mem();
        wr(A_SRC, 32'h00); wr(A_DST, 32'h80); wr(A_CNT, 32'd0);
        wr(A_CMD, C_SINC | C_DINC | (32'd2 << 8) | C_IRQ);
        wr(A_STS, 32'h1);
        rd(A_STS, v); chk("R8", v, 32'h1, "not yet done before next edge");
        @(posedge clk);
        rd(A_STS, v); chk("R8", v, 32'hB, "done one edge after enable");
        repeat (3) @(posedge clk);
        chk("R8", 32'(accesses), 32'd0, "no access for zero count");
        clear_status();
    endtask

    task automatic t_gating();
        logic [31:0] v;
        init_mem();
        wr(A_GCTL, 32'h9);
        wr(A_SRC, 32'h00); wr(A_DST, 32'h80); wr(A_CNT, 32'd4);
        wr(A_CMD, C_SINC | C_DINC | (32'd2 << 8));
        wr(A_STS, 32'h1);
        repeat (20) @(posedge clk);
        rd(A_CNT, v); chk("R9", v, 32'd4, "global halt freezes count");
        wr(A_GCTL, 32'h0);
        repeat (20) @(posedge clk);
        rd(A_CNT, v); chk("R9", v, 32'd4, "global disable freezes count");
        wr(A_GCTL, 32'h1);
        wr(A_STS, 32'h5);
        repeat (20) @(posedge clk);
        rd(A_CNT, v); chk("R9", v, 32'd4, "channel halt freezes count");
        chk("R9", 32'(accesses), 32'd0, "no access while gated");
        wr(A_STS, 32'h1);
        wait_done(200);
        chk("R9", 32'(mism(8'h80, 0, 16)), 32'h0, "completes after release");
        clear_status();
    endtask

    task automatic t_no_irq();
        logic [31:0] v;
        init_mem();
        wr(A_SRC, 32'h00); wr(A_DST, 32'h80); wr(A_CNT, 32'd1);
        wr(A_CMD, C_SINC | C_DINC | (32'd2 << 8));
        wr(A_STS, 32'h1);
        wait_done(200);
        rd(A_STS, v); chk("R6", {28'd0, v[3:0]}, 32'hB, "done with irq disabled");
        chk("R6", {31'd0, irq}, 32'h0, "irq masked");
        rd(A_PEND, v); chk("R6", v, 32'h0, "pending masked");
        clear_status();
    endtask

    task automatic t_request_mode();
        logic [31:0] v;
        init_mem();
        wr(A_RQT, 32'h1);
        wr(A_SRC, 32'h40); wr(A_DST, 32'hE0); wr(A_CNT, 32'd3);
        wr(A_CMD, C_SINC | C_DINC | (32'd2 << 8));
        wr(A_STS, 32'h1);
        repeat (20) @(posedge clk);
        rd(A_CNT, v); chk("R10", v, 32'd3, "no unit without request");
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
        repeat (10) @(posedge clk);
        rd(A_CNT, v); chk("R5", v, 32'd2, "one unit per request pulse");
        rd(A_SRC, v); chk("R10", v, 32'h44, "source advanced mid transfer");
        rd(A_DST, v); chk("R3", v, 32'hE4, "destination advanced mid transfer");
        @(negedge clk); dreq = 1'b1;
        wait_done(200);
        @(negedge clk); dreq = 1'b0;
        chk("R10", 32'(mism(8'hE0, 8'h40, 12)), 32'h0, "request mode data");
        clear_status();
        wr(A_RQT, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin mem_b[i] = '0; gold[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_word_copy();
        t_byte_lanes();
        t_burst();
        t_fixed_dst();
        t_misalign();
        t_zero_count();
        t_gating();
        t_no_irq();
        t_request_mode();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule